// File: doc/BRIEF.md
# Selectable Phase Accumulator with Offset

This block is the phase engine of a numerically controlled oscillator. On every rising clock edge it adds one of two 28-bit tuning words to a 28-bit phase accumulator that wraps modulo 2^28. The top 12 bits of the accumulator are then shifted by one of two 12-bit phase offsets, modulo 4096, and the sum is registered as the output phase word. A downstream lookup turns that word into a waveform. The output frequency is the clock rate times the tuning word divided by 2^28. Each offset step moves the output by 1/4096 of a cycle.

Two select lines choose the active tuning word and the active offset. A source-mode input decides where those lines come from. They come either from two external select pins or from two control bits that a register block drives synchronously. The pins may change with no relation to the clock. They are captured on the falling clock edge and captured again on the next rising edge before they reach the multiplexers. A clear flag holds the accumulator at zero for as long as it is set.

Top module: `phase_nco_core`

## Requirements
- R1: On each rising edge with the clear flag low, the accumulator advances by the selected tuning word, modulo 2^28.
- R2: After each rising edge, `phase_o` equals accumulator bits [27:16] as they stood before that edge, plus the selected offset, modulo 4096.
- R3: When `pin_mode_i` is 1, the pins choose the registers. A sampled `fsel_pin_i` of 0 picks `freq0_i` and 1 picks `freq1_i`. A sampled `psel_pin_i` of 0 picks `phase0_i` and 1 picks `phase1_i`.
- R4: When `pin_mode_i` is 0, `fsel_bit_i` and `psel_bit_i` choose the registers with the same 0/1 encoding, and they act at the next rising edge. The pins then have no effect on `phase_o`.
- R5: A pin is sampled on the falling clock edge. The value caught at a falling edge governs the second rising edge that follows it, so a pulse that spans only a falling edge still takes effect.
- R6: While `rst_n` is low, the accumulator, both sampled pins and `phase_o` are 0, whatever the clock is doing.
- R7: While `acc_clr_i` is 1, the accumulator is 0 after each rising edge and `phase_o` carries the selected offset alone.
- R8: The frequency select and the phase select act independently, so any pairing of tuning word and offset can be active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; rising edge updates state, falling edge samples pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| freq0_i | input | 28 | Tuning word 0 |
| freq1_i | input | 28 | Tuning word 1 |
| phase0_i | input | 12 | Phase offset 0 |
| phase1_i | input | 12 | Phase offset 1 |
| fsel_pin_i | input | 1 | External frequency select pin |
| psel_pin_i | input | 1 | External phase select pin |
| pin_mode_i | input | 1 | 1: pins select, 0: control bits select |
| fsel_bit_i | input | 1 | Control-bit frequency select |
| psel_bit_i | input | 1 | Control-bit phase select |
| acc_clr_i | input | 1 | Holds the accumulator at zero while 1 |
| phase_o | output | 12 | Offset output phase word |

## Verification
The accumulator is tried with small words, with words whose carries reach the output bits, and with a word near 2^28 that forces a wrap. These patterns separate a correct modulo-2^28 add from a truncated or saturating one. Offsets are chosen so that the output sum crosses 4095, which exposes a wrong slice or a missing wrap. Pin-driven selection is tried with steady pins and with a short pulse that spans only a falling edge. This separates falling-edge sampling from rising-edge sampling and checks the two-edge latency. Pins are toggled in bit mode, and the two selects are given opposite values, to show that the sources and the select paths stay apart.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned NCO_ACC_W = 28;
  localparam int unsigned NCO_OUT_W = 12;

  typedef enum logic {
    SRC_CTRL = 1'b0,
    SRC_PIN  = 1'b1
  } sel_src_e;
endpackage

// File: rtl/nco_pin_sampler.sv
module nco_pin_sampler #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_o
);
  logic [N-1:0] fall_q;
  logic [N-1:0] rise_q;

  // first capture on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= pin_i;
  end

  // second capture moves the value into the rising-edge domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= fall_q;
  end

  assign pin_o = rise_q;
endmodule

// File: rtl/nco_reg_select.sv
module nco_reg_select
  import nco_pkg::*;
#(
  parameter int unsigned W = 28
) (
  input  sel_src_e       src_i,
  input  logic           pin_sel_i,
  input  logic           bit_sel_i,
  input  logic [W-1:0]   reg0_i,
  input  logic [W-1:0]   reg1_i,
  output logic [W-1:0]   val_o
);
  logic sel;

  always_comb begin
    sel   = (src_i == SRC_PIN) ? pin_sel_i : bit_sel_i;
    val_o = sel ? reg1_i : reg0_i;
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  // next state: a zero increment needs no update
  always_comb begin
    acc_en = clr_i || (inc_i != '0);
    acc_d  = clr_i ? '0 : acc_q + inc_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/nco_phase_offset.sv
module nco_phase_offset #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned OUT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [OUT_W-1:0] off_i,
  output logic [OUT_W-1:0] phase_o
);
  localparam int unsigned TOP_LSB = ACC_W - OUT_W;

  logic [OUT_W-1:0] phase_q;
  logic [OUT_W-1:0] phase_d;

  always_comb begin
    phase_d = acc_i[ACC_W-1:TOP_LSB] + off_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/phase_nco_core.sv
module phase_nco_core
  import nco_pkg::*;
#(
  parameter int unsigned ACC_W = NCO_ACC_W,
  parameter int unsigned OUT_W = NCO_OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq0_i,
  input  logic [ACC_W-1:0] freq1_i,
  input  logic [OUT_W-1:0] phase0_i,
  input  logic [OUT_W-1:0] phase1_i,
  input  logic             fsel_pin_i,
  input  logic             psel_pin_i,
  input  logic             pin_mode_i,
  input  logic             fsel_bit_i,
  input  logic             psel_bit_i,
  input  logic             acc_clr_i,
  output logic [OUT_W-1:0] phase_o
);
  localparam int unsigned N_PINS = 2;

  logic [N_PINS-1:0] pins_raw;
  logic [N_PINS-1:0] pins_sync;
  sel_src_e          src;
  logic [ACC_W-1:0]  freq_sel;
  logic [OUT_W-1:0]  poff_sel;
  logic [ACC_W-1:0]  acc_q;

  assign pins_raw = {psel_pin_i, fsel_pin_i};
  assign src      = pin_mode_i ? SRC_PIN : SRC_CTRL;

  nco_pin_sampler #(.N(N_PINS)) u_pins (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins_raw),
    .pin_o (pins_sync)
  );

  nco_reg_select #(.W(ACC_W)) u_fsel (
    .src_i     (src),
    .pin_sel_i (pins_sync[0]),
    .bit_sel_i (fsel_bit_i),
    .reg0_i    (freq0_i),
    .reg1_i    (freq1_i),
    .val_o     (freq_sel)
  );

  nco_reg_select #(.W(OUT_W)) u_psel (
    .src_i     (src),
    .pin_sel_i (pins_sync[1]),
    .bit_sel_i (psel_bit_i),
    .reg0_i    (phase0_i),
    .reg1_i    (phase1_i),
    .val_o     (poff_sel)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (acc_clr_i),
    .inc_i (freq_sel),
    .acc_o (acc_q)
  );

  nco_phase_offset #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_off (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_i   (acc_q),
    .off_i   (poff_sel),
    .phase_o (phase_o)
  );
endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk #(
  parameter int unsigned ACC_W = 28,
  parameter int unsigned OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_clr_i,
  input logic             pin_mode_i,
  input logic             fsel_bit_i,
  input logic [ACC_W-1:0] freq0_i,
  input logic [ACC_W-1:0] acc_q,
  input logic [ACC_W-1:0] freq_sel,
  input logic [OUT_W-1:0] poff_sel,
  input logic [OUT_W-1:0] phase_o
);
  logic [OUT_W-1:0] acc_top;
  logic [OUT_W-1:0] out_expect;
  assign acc_top    = acc_q[ACC_W-1:ACC_W-OUT_W];
  assign out_expect = acc_top + poff_sel;

  assert_acc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clr_i |=> acc_q == ($past(acc_q) + $past(freq_sel)));

  assert_out_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_o == $past(out_expect));

  assert_bit_mode_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_mode_i && !fsel_bit_i) |-> freq_sel == freq0_i);

  assert_clear_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr_i |=> acc_q == '0);
endmodule

bind phase_nco_core nco_core_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_clr_i  (acc_clr_i),
  .pin_mode_i (pin_mode_i),
  .fsel_bit_i (fsel_bit_i),
  .freq0_i    (freq0_i),
  .acc_q      (acc_q),
  .freq_sel   (freq_sel),
  .poff_sel   (poff_sel),
  .phase_o    (phase_o)
);

// File: tb/phase_nco_core_bench.sv
`timescale 1ns/100ps
module phase_nco_core_bench;
  logic        clk;
  logic        rst_n;
  logic [27:0] freq0, freq1;
  logic [11:0] ph0, ph1;
  logic        fpin, ppin, mode, fbit, pbit, clr;
  logic [11:0] phase_o;

  int checks;
  int errors;
  bit done;

  // reference state derived from the requirements
  logic [27:0] m_acc;
  logic        m_fs, m_ps;
  bit          pulse;
  logic        pulse_f, pulse_p;

  phase_nco_core u_phase_nco_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .freq0_i    (freq0),
    .freq1_i    (freq1),
    .phase0_i   (ph0),
    .phase1_i   (ph1),
    .fsel_pin_i (fpin),
    .psel_pin_i (ppin),
    .pin_mode_i (mode),
    .fsel_bit_i (fbit),
    .psel_bit_i (pbit),
    .acc_clr_i  (clr),
    .phase_o    (phase_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: phase_o=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle: pins observed at the falling edge, model updated at the rising edge
  task automatic tick(input string req);
    logic nf, np, uf, up;
    logic [11:0] exp;
    @(negedge clk);
    nf = fpin;
    np = ppin;
    if (pulse) begin
      #1;
      fpin  = pulse_f;
      ppin  = pulse_p;
      pulse = 0;
    end
    @(posedge clk);
    uf  = mode ? m_fs : fbit;
    up  = mode ? m_ps : pbit;
    exp = m_acc[27:16] + (up ? ph1 : ph0);
    m_acc = clr ? 28'd0 : m_acc + (uf ? freq1 : freq0);
    m_fs = nf;
    m_ps = np;
    #1;
    check(req, phase_o, exp);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    check("R6", phase_o, 12'h000);
    m_acc = '0; m_fs = 1'b0; m_ps = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R6", phase_o, 12'h000);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    freq0 = 28'h0010000; ph0 = 12'h000;
    tick("R6");
    check("R6", phase_o, 12'h000);
  endtask

  task automatic t_bits_mode();
    mode = 0; fbit = 0; pbit = 0;
    freq0 = 28'h0123456; freq1 = 28'h0F00000; ph0 = 12'h010; ph1 = 12'h800;
    for (int i = 0; i < 6; i++) begin
      fpin = i[0]; ppin = ~i[0];   // pins toggle but must not matter (R4)
      tick("R4");
    end
    fbit = 1; pbit = 1;
    for (int i = 0; i < 6; i++) begin
      fpin = ~i[0]; ppin = i[1];
      tick("R4");
    end
  endtask

  task automatic t_pin_mode();
    fbit = 0; pbit = 0;
    fpin = 1; ppin = 0;
    mode = 1;
    for (int i = 0; i < 4; i++) tick("R3");
    fpin = 0; ppin = 1;
    fbit = 1; pbit = 0;          // bits must not matter in pin mode
    for (int i = 0; i < 4; i++) tick("R3");
  endtask

  task automatic t_falling_pulse();
    mode = 1; fpin = 0; ppin = 0;
    freq0 = 28'h0000000; freq1 = 28'h4000000;
    ph0 = 12'h000; ph1 = 12'h123;
    for (int i = 0; i < 3; i++) tick("R5");
    // pulse high across one falling edge only
    fpin = 1; ppin = 1; pulse = 1; pulse_f = 0; pulse_p = 0;
    for (int i = 0; i < 4; i++) tick("R5");
  endtask

  task automatic t_wrap();
    mode = 0; fbit = 1; pbit = 0;
    freq1 = 28'hFFFF000; ph0 = 12'h7F0;
    for (int i = 0; i < 8; i++) tick("R1");
    freq1 = 28'h9876543;
    for (int i = 0; i < 8; i++) tick("R1");
  endtask

  task automatic t_offset_wrap();
    mode = 0; fbit = 0; pbit = 1;
    freq0 = 28'h0F10000; ph1 = 12'hFFE;
    for (int i = 0; i < 8; i++) tick("R2");
  endtask

  task automatic t_clear();
    mode = 0; fbit = 1; pbit = 1;
    freq1 = 28'h0555555; ph1 = 12'h3A5;
    clr = 1;
    for (int i = 0; i < 4; i++) tick("R7");
    check("R7", phase_o, 12'h3A5);
    clr = 0;
    for (int i = 0; i < 3; i++) tick("R7");
  endtask

  task automatic t_independent();
    mode = 0; fbit = 1; pbit = 0;
    freq0 = 28'h0001000; freq1 = 28'h0200000; ph0 = 12'h0AA; ph1 = 12'h555;
    for (int i = 0; i < 4; i++) tick("R8");
    fbit = 0; pbit = 1;
    for (int i = 0; i < 4; i++) tick("R8");
    mode = 1; fpin = 1; ppin = 0;
    for (int i = 0; i < 4; i++) tick("R8");
  endtask

  task automatic t_mid_reset();
    mode = 1; fpin = 1; ppin = 1;
    for (int i = 0; i < 3; i++) tick("R6");
    do_reset();
    for (int i = 0; i < 4; i++) tick("R6");
  endtask

  initial begin
    checks = 0; errors = 0; done = 0; pulse = 0;
    pulse_f = 0; pulse_p = 0;
    rst_n = 1'b0;
    freq0 = '0; freq1 = '0; ph0 = '0; ph1 = '0;
    fpin = 0; ppin = 0; mode = 0; fbit = 0; pbit = 0; clr = 0;
    m_acc = '0; m_fs = 0; m_ps = 0;
    t_reset_state();
    t_bits_mode();
    t_pin_mode();
    t_falling_pulse();
    t_wrap();
    t_offset_wrap();
    t_clear();
    t_independent();
    t_mid_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule